// File: doc/BRIEF.md
# Serial Receive Character Queue with Status Mode

This block sits behind the deserializer of one serial channel. Every character that the deserializer delivers arrives with three error flags: line break, framing and parity. It also carries a per-character overrun flag. The block stores the character and its flags in a queue of 1023 entries. The host empties the queue through a 16-bit data port, and each read returns one of two formats. In packed mode a read returns two characters. In status mode a read returns one character with its error flags beside it.

The block also keeps a channel status word. Its low byte shows the modem lines and transmit-side flags as they are now, together with a data-available bit. Its high byte holds the status-mode control bit and a set of sticky receive events. A host read of the word clears these events. A trigger output rises once the queue holds a programmable number of characters. The trigger works apart from any interrupt enable. A flush input empties the queue in one cycle. Characters are taken only while the receive-enable input is high.

Top module: `rx_char_fifo`

## Requirements
- R1: The queue holds up to 1023 characters in arrival order, and `rx_count` gives the number stored, one cycle after the push or pop that changes it.
- R2: A character is stored only when `rx_enable` and `chr_vld` are both high. With `rx_enable` low the strobe leaves the count, the data port and the status word unchanged.
- R3: In status mode, `data_rdata[7:0]` is the oldest character. `data_rdata[11:8]` holds its flags: break 0x08, framing 0x04, overrun 0x02, parity 0x01. `data_rdata[15:12]` is zero. A read removes one character.
- R4: In packed mode, `data_rdata[7:0]` is the oldest character and `[15:8]` is the next one. A read removes two characters. With one stored, the high byte is zero and only that one is removed. With none stored the port reads zero and a read changes nothing.
- R5: A status write copies `stat_wdata[15]` into the status-mode bit, shown at `stat_rdata[15]`, and ignores all other write bits.
- R6: `stat_rdata[5:0]` shows the present values of CTS (0x20), DSR (0x10), CD (0x08), transmit queue empty (0x04), transmit shifter empty (0x02) and data available (0x01, queue not empty). Bits 7:6 and bit 14 read zero.
- R7: A stored character sets sticky bits for its errors: break 0x0400, framing 0x0200, parity 0x0100. The compare strobes set 0x0800 (compare 1) and 0x1000 (compare 2). Each bit becomes visible one cycle later.
- R8: A character offered while 1023 are already stored is dropped, and the overflow sticky bit 0x2000 is set.
- R9: A status read returns the current word and clears bits 13:8 in the next cycle. The status-mode bit is kept. An event in the same cycle as the read stays set.
- R10: `trig` follows the level selected by `trig_sel`: 0 never; 1 at one or more characters; 2 at 512 or more; 3 at 896 or more. It falls as soon as the count drops below the level.
- R11: `flush` empties the queue in one cycle. It discards any character offered and any read in that cycle, and it leaves the sticky bits unchanged.
- R12: After reset the count is zero, status mode is off, the sticky bits are clear and `trig` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive processing enable |
| chr_vld | input | 1 | Character strobe from deserializer |
| chr_data | input | 8 | Received character |
| chr_brk | input | 1 | Character flagged as line break |
| chr_frm | input | 1 | Character has framing error |
| chr_ovr | input | 1 | Character follows a deserializer overrun |
| chr_par | input | 1 | Character has parity error |
| cmp1_hit | input | 1 | Compare-1 match event |
| cmp2_hit | input | 1 | Compare-2 match event |
| flush | input | 1 | Empty the queue |
| trig_sel | input | 2 | Trigger level select |
| cts_in | input | 1 | CTS line state |
| dsr_in | input | 1 | DSR line state |
| cd_in | input | 1 | CD line state |
| tx_fifo_empty | input | 1 | Transmit queue empty |
| tx_shift_empty | input | 1 | Transmit shifter empty |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 16 | Status word write data |
| stat_rd | input | 1 | Status word read strobe |
| stat_rdata | output | 16 | Status word |
| data_rd | input | 1 | Data port read strobe |
| data_rdata | output | 16 | Data port read value |
| rx_count | output | 16 | Characters stored |
| trig | output | 1 | Fill level reached |

## Verification
The data port, the live status bits and `trig` are combinational from the stored state. They are due in the same cycle as the inputs that select them. A push, pop, flush, status write or sticky set or clear shows one clock edge later. The bench drives each cycle's inputs after the falling edge and compares every output a short delay later, before the rising edge. Only then does it advance a queue-based reference model by that cycle's stimulus. Each result is therefore compared in exactly the cycle it is due.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       ovr;
        logic       par;
        logic [7:0] data;
    } rx_char_t;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_ONE  = 2'd1,
        TRIG_HALF = 2'd2,
        TRIG_7_8  = 2'd3
    } trig_sel_e;

    typedef struct packed {
        logic ovf;
        logic cmp2;
        logic cmp1;
        logic brk;
        logic frm;
        logic par;
    } sticky_t;

    // ring pointer advance for a non power-of-two depth
    function automatic logic [31:0] ring_add(logic [31:0] p, logic [31:0] n, logic [31:0] depth);
        logic [31:0] s;
        s = p + n;
        return (s >= depth) ? s - depth : s;
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 1023,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  rx_char_t         wchar,
    input  logic [1:0]       pop_n,
    input  logic             flush,
    output rx_char_t         head0,
    output rx_char_t         head1,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);

    rx_char_t         mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr, rptr1;

    assign rptr1 = PTR_W'(ring_add(32'(rptr), 32'd1, 32'(DEPTH)));
    assign head0 = mem[rptr];
    assign head1 = mem[rptr1];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wchar;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= PTR_W'(ring_add(32'(wptr), 32'd1, 32'(DEPTH)));
            rptr  <= PTR_W'(ring_add(32'(rptr), 32'(pop_n), 32'(DEPTH)));
            count <= count + CNT_W'(push) - CNT_W'(pop_n);
        end
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> count == '0);

endmodule

// File: rtl/rxq_status.sv
`timescale 1ns/1ps
module rxq_status
    import rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic        wmode,
    input  logic        rd,
    input  sticky_t     ev,
    input  logic [5:0]  live,
    output logic        mode,
    output logic [15:0] word
);
    sticky_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            mode <= 1'b0;
        end else begin
            st <= (rd ? sticky_t'('0) : st) | ev;
            if (wr) mode <= wmode;
        end
    end

    assign word = {mode, 1'b0, st.ovf, st.cmp2, st.cmp1, st.brk, st.frm, st.par,
                   2'b00, live};

    // R9
    sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && ev == '0) |=> word[13:8] == 6'd0);

    // R5
    mode_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> mode == $past(wmode));

endmodule

// File: rtl/rxq_trigger.sv
`timescale 1ns/1ps
module rxq_trigger
    import rxq_pkg::*;
#(
    parameter int DEPTH = 1023,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       sel,
    output logic             trig
);
    localparam int HALF_LVL  = (DEPTH + 1) / 2;
    localparam int SEVEN_LVL = ((DEPTH + 1) * 7) / 8;

    always_comb begin
        unique case (trig_sel_e'(sel))
            TRIG_OFF:  trig = 1'b0;
            TRIG_ONE:  trig = count != '0;
            TRIG_HALF: trig = count >= CNT_W'(HALF_LVL);
            TRIG_7_8:  trig = count >= CNT_W'(SEVEN_LVL);
            default:   trig = 1'b0;
        endcase
    end

    // R10
    trig_empty_chk: assert property (@(posedge clk) disable iff (rst)
        count == '0 |-> !trig);

endmodule

// File: rtl/rx_char_fifo.sv
`timescale 1ns/1ps
module rx_char_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 1023,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_enable,
    input  logic             chr_vld,
    input  logic [7:0]       chr_data,
    input  logic             chr_brk,
    input  logic             chr_frm,
    input  logic             chr_ovr,
    input  logic             chr_par,
    input  logic             cmp1_hit,
    input  logic             cmp2_hit,
    input  logic             flush,
    input  logic [1:0]       trig_sel,
    input  logic             cts_in,
    input  logic             dsr_in,
    input  logic             cd_in,
    input  logic             tx_fifo_empty,
    input  logic             tx_shift_empty,
    input  logic             stat_wr,
    input  logic [15:0]      stat_wdata,
    input  logic             stat_rd,
    output logic [15:0]      stat_rdata,
    input  logic             data_rd,
    output logic [15:0]      data_rdata,
    output logic [CNT_W-1:0] rx_count,
    output logic             trig
);
    rx_char_t   wchar, head0, head1;
    sticky_t    ev;
    logic       full, take, push, mode, have2, empty;
    logic [1:0] pop_n;
    logic [5:0] live;
    logic       unused_wbits;

    assign unused_wbits = ^stat_wdata[14:0];

    assign empty = rx_count == '0;
    assign have2 = rx_count >= CNT_W'(2);
    assign full  = rx_count == CNT_W'(DEPTH);
    assign take  = rx_enable && chr_vld && !flush;
    assign push  = take && !full;
    assign wchar = '{brk: chr_brk, frm: chr_frm, ovr: chr_ovr, par: chr_par, data: chr_data};

    always_comb begin
        ev      = '0;
        ev.ovf  = take && full;
        ev.brk  = push && chr_brk;
        ev.frm  = push && chr_frm;
        ev.par  = push && chr_par;
        ev.cmp1 = cmp1_hit;
        ev.cmp2 = cmp2_hit;
    end

    always_comb begin
        if (flush || !data_rd || empty) pop_n = 2'd0;
        else if (mode || !have2)        pop_n = 2'd1;
        else                            pop_n = 2'd2;
    end

    always_comb begin
        if (empty)     data_rdata = 16'h0000;
        else if (mode) data_rdata = {4'h0, head0.brk, head0.frm, head0.ovr, head0.par, head0.data};
        else           data_rdata = {have2 ? head1.data : 8'h00, head0.data};
    end

    assign live = {cts_in, dsr_in, cd_in, tx_fifo_empty, tx_shift_empty, !empty};

    rxq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wchar (wchar),
        .pop_n (pop_n),
        .flush (flush),
        .head0 (head0),
        .head1 (head1),
        .count (rx_count)
    );

    rxq_status u_status (
        .clk   (clk),
        .rst   (rst),
        .wr    (stat_wr),
        .wmode (stat_wdata[15]),
        .rd    (stat_rd),
        .ev    (ev),
        .live  (live),
        .mode  (mode),
        .word  (stat_rdata)
    );

    rxq_trigger #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
        .clk   (clk),
        .rst   (rst),
        .count (rx_count),
        .sel   (trig_sel),
        .trig  (trig)
    );

    // R8
    ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_enable && chr_vld && !flush && rx_count == CNT_W'(DEPTH)) |=> stat_rdata[13]);

    // R2
    rx_off_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> rx_count <= $past(rx_count));

endmodule

// File: tb/rx_char_fifo_bench.sv
`timescale 1ns/1ps
module rx_char_fifo_bench;
    localparam int DEPTH = 1023;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_enable = 0, chr_vld = 0, chr_brk = 0, chr_frm = 0, chr_ovr = 0, chr_par = 0;
    logic [7:0] chr_data = 0;
    logic cmp1_hit = 0, cmp2_hit = 0, flush = 0;
    logic [1:0] trig_sel = 0;
    logic cts_in = 0, dsr_in = 0, cd_in = 0, tx_fifo_empty = 0, tx_shift_empty = 0;
    logic stat_wr = 0, stat_rd = 0, data_rd = 0;
    logic [15:0] stat_wdata = 0;
    logic [15:0] stat_rdata, data_rdata, rx_count;
    logic trig;

    always #4 clk = ~clk;

    rx_char_fifo u_rx_char_fifo (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .chr_vld(chr_vld), .chr_data(chr_data),
        .chr_brk(chr_brk), .chr_frm(chr_frm), .chr_ovr(chr_ovr), .chr_par(chr_par),
        .cmp1_hit(cmp1_hit), .cmp2_hit(cmp2_hit), .flush(flush), .trig_sel(trig_sel),
        .cts_in(cts_in), .dsr_in(dsr_in), .cd_in(cd_in), .tx_fifo_empty(tx_fifo_empty),
        .tx_shift_empty(tx_shift_empty), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata), .data_rd(data_rd),
        .data_rdata(data_rdata), .rx_count(rx_count), .trig(trig)
    );

    int vectors = 0;
    int fails = 0;

    // reference model
    int   q[$];
    bit   m_mode = 0;
    bit [5:0] m_stk = 0; // ovf, cmp2, cmp1, brk, frm, par

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock cycle: inputs already driven after the falling edge
    task automatic tick();
        int cnt, e0, e1;
        bit tk, lvl;
        bit [5:0] nstk;
        logic [15:0] ed;
        #1;
        cnt = q.size();
        e0 = (cnt > 0) ? q[0] : 0;
        e1 = (cnt > 1) ? q[1] : 0;
        if (cnt == 0)   ed = 16'h0;
        else if (m_mode) ed = {4'h0, 12'(e0)};
        else            ed = {(cnt > 1) ? 8'(e1) : 8'h00, 8'(e0)};
        chk("R1 count", rx_count, 16'(cnt));
        chk(m_mode ? "R3 status-mode data" : "R4 packed data", data_rdata, ed);
        chk("R7 status word", stat_rdata,
            {m_mode, 1'b0, m_stk, 2'b00, cts_in, dsr_in, cd_in, tx_fifo_empty, tx_shift_empty, cnt != 0});
        case (trig_sel)
            2'd0: lvl = 0;
            2'd1: lvl = cnt >= 1;
            2'd2: lvl = cnt >= 512;
            default: lvl = cnt >= 896;
        endcase
        chk("R10 trigger", {15'h0, trig}, {15'h0, lvl});
        // advance model
        tk = rx_enable && chr_vld && !flush;
        nstk = stat_rd ? 6'b0 : m_stk;
        if (!flush && data_rd && cnt > 0) begin
            void'(q.pop_front());
            if (!m_mode && cnt > 1) void'(q.pop_front());
        end
        if (tk) begin
            if (cnt == DEPTH) nstk[5] = 1;
            else begin
                q.push_back({chr_brk, chr_frm, chr_ovr, chr_par, chr_data});
                if (chr_brk) nstk[2] = 1;
                if (chr_frm) nstk[1] = 1;
                if (chr_par) nstk[0] = 1;
            end
        end
        if (cmp1_hit) nstk[3] = 1;
        if (cmp2_hit) nstk[4] = 1;
        if (flush) q.delete();
        if (stat_wr) m_mode = stat_wdata[15];
        m_stk = nstk;
        @(posedge clk);
        @(negedge clk);
        chr_vld = 0; chr_brk = 0; chr_frm = 0; chr_ovr = 0; chr_par = 0;
        cmp1_hit = 0; cmp2_hit = 0; flush = 0; stat_wr = 0; stat_rd = 0; data_rd = 0;
        stat_wdata = 0;
    endtask

    task automatic send(logic [7:0] d, logic [3:0] errs);
        chr_vld = 1; chr_data = d;
        {chr_brk, chr_frm, chr_ovr, chr_par} = errs;
        tick();
    endtask

    task automatic set_mode(bit md);
        stat_wr = 1; stat_wdata = {md, 15'h7FFF}; // R5: low bits ignored
        tick();
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        #1;
        chk("R12 count", rx_count, 16'h0);
        chk("R12 status", stat_rdata, 16'h0);
        chk("R12 trig", {15'h0, trig}, 16'h0);
        @(negedge clk);

        // R6 live lines
        cts_in = 1; cd_in = 1; tx_fifo_empty = 1; tick();
        dsr_in = 1; cts_in = 0; tx_shift_empty = 1; tick();

        // R2 receive disabled
        send(8'h11, 4'hF); send(8'h12, 4'h0);

        // R7 errors become sticky
        rx_enable = 1; trig_sel = 1;
        send(8'h41, 4'h0); send(8'h42, 4'h1); send(8'h43, 4'hC); send(8'h44, 4'h2);
        cmp1_hit = 1; tick();
        // R9 clear on read, then event racing a read
        stat_rd = 1; tick(); tick();
        stat_rd = 1; cmp2_hit = 1; tick(); tick();
        stat_rd = 1; tick();

        // R4 packed read of two
        data_rd = 1; tick();
        // R3 status mode reads
        set_mode(1);
        data_rd = 1; tick();
        data_rd = 1; tick();
        data_rd = 1; tick(); // empty read
        // R4 odd count in packed mode
        set_mode(0);
        send(8'h55, 4'h0);
        data_rd = 1; tick();
        data_rd = 1; tick();

        // R1/R8/R10 fill to capacity
        trig_sel = 2;
        for (int i = 0; i < DEPTH; i++) begin
            if (i == 600) trig_sel = 3;
            send(8'(i * 7 + 3), (i % 97 == 0) ? 4'h1 : 4'h0);
        end
        send(8'hEE, 4'h0);                       // R8 dropped
        stat_rd = 1; tick();
        stat_rd = 1; chr_vld = 1; chr_data = 8'hEF; tick(); // R8 with read same cycle
        // push and pop when full
        data_rd = 1; chr_vld = 1; chr_data = 8'hF0; tick();
        trig_sel = 0; tick();
        // drain in packed mode through both trigger levels
        trig_sel = 3;
        for (int i = 0; i < 70; i++) begin data_rd = 1; tick(); end
        trig_sel = 2;
        for (int i = 0; i < 200; i++) begin data_rd = 1; tick(); end
        set_mode(1);
        for (int i = 0; i < 20; i++) begin data_rd = 1; tick(); end

        // R11 flush with a character and read offered, sticky kept
        send(8'hA0, 4'h8);
        flush = 1; chr_vld = 1; chr_data = 8'hA1; data_rd = 1; tick();
        tick();
        // refill after flush keeps order
        trig_sel = 1;
        send(8'h01, 4'h4); send(8'h02, 4'h0);
        data_rd = 1; tick();
        set_mode(0);
        data_rd = 1; tick();
        stat_rd = 1; tick(); tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule